// File: doc/BRIEF.md
# Operand Bypass and Load-Use Hazard Controller

This block is the control half of the bypass network in a five-stage in-order pipeline. It has two EX-stage operand multiplexers to steer. For each one it chooses among three sources: the value latched in the ID/EX register, the ALU result held in the EX/MEM register, or the final write-back value. The write-back value is either the ALU result or load data. The block also steers the two ID-stage read ports around the register file whenever the write-back stage is writing the register being read.

A load result exists only in the write-back stage. A load's result therefore cannot be forwarded to the instruction right behind it. The block detects that pairing and asks the pipeline to stall for one cycle. The pipeline holds the PC and IF/ID and places a bubble in ID/EX. One cycle later the load sits in WB and the dependent instruction sits in EX, and the ordinary write-back path delivers the value.

The unit is purely combinational. Every output depends only on the current register numbers, write enables and load flags. It holds no state, so the house state-machine form reduces to a single decision per cycle. The choices are taken in a fixed priority: the newest producer wins, followed by the older producer, followed by the register file.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An EX operand select is 2'b00 (register value) when no eligible producer matches. The encodings are 2'b00 for the register value, 2'b01 for the EX/MEM result and 2'b10 for the write-back value, and 2'b11 never appears.
- R2: An EX operand select is 2'b01 when its source equals the MEM destination and the MEM stage writes a register and is not a load.
- R3: An EX operand select is 2'b10 when its source equals the WB destination with WB writing, and no MEM forward applies.
- R4: When both MEM and WB are eligible for the same operand, the select is 2'b01 (the newer value wins).
- R5: Register zero is never forwarded, never bypassed in ID and never causes a stall.
- R6: A stage whose write enable is low is never used as a source and never causes a stall.
- R7: A load in MEM is never forwarded from EX/MEM. A matching operand uses WB if WB matches, otherwise the register value.
- R8: An ID bypass bit is 1 exactly when that ID source equals the WB destination, the WB stage is writing, and the source is not zero.
- R9: The stall output is 1 when EX holds a writing load whose destination equals either ID source.
- R10: The stall output is 0 when the EX producer is not a load, even if its destination matches.
- R11: In the stall sequence (a load in EX with a dependent in ID, then a bubble in EX, then the dependent in EX with the load in WB), stall is 1 only in the first cycle and the dependent operand selects 2'b10 in the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | AW | First source register number of the ID instruction |
| id_src_b | input | AW | Second source register number of the ID instruction |
| ex_src_a | input | AW | First source register number of the EX instruction |
| ex_src_b | input | AW | Second source register number of the EX instruction |
| ex_dst | input | AW | Destination register of the EX instruction |
| ex_wr | input | 1 | EX instruction writes a register |
| ex_load | input | 1 | EX instruction is a load |
| mem_dst | input | AW | Destination register of the MEM instruction |
| mem_wr | input | 1 | MEM instruction writes a register |
| mem_load | input | 1 | MEM instruction is a load |
| wb_dst | input | AW | Destination register of the WB instruction |
| wb_wr | input | 1 | WB instruction writes a register |
| ex_sel_a | output | 2 | Mux select for EX operand A |
| ex_sel_b | output | 2 | Mux select for EX operand B |
| id_byp_a | output | 1 | Take the WB value in place of register file port A |
| id_byp_b | output | 1 | Take the WB value in place of register file port B |
| stall | output | 1 | One-cycle load-use stall request |

## Verification
The bench targets operands that match MEM and WB at the same time. A design with the priority reversed would feed stale write-back data to the ALU there. It also covers sources equal to zero with matching destinations, where a careless unit forwards a garbage value into r0 reads. Loads in MEM must not be taken from the EX/MEM register, which holds only an address at that point. ALU producers in EX must not cause stalls, since a spurious stall costs throughput while a missing one corrupts data. The three-cycle load-use sequence is checked end to end, so that the value arrives through the WB path after exactly one bubble.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // EX operand source select encoding
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_ex_select.sv
module fwd_ex_select
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_load,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output fwd_sel_e      sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        src_live = (src != ZERO_REG);
        // EX/MEM holds an address, not data, for a load
        mem_hit  = src_live && mem_wr && !mem_load && (mem_dst == src);
        wb_hit   = src_live && wb_wr && (wb_dst == src);
    end

    // Newest producer first
    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = FWD_MEM;
            2'b01:        sel = FWD_WB;
            default:      sel = FWD_RF;
        endcase
    end
endmodule

// File: rtl/fwd_id_bypass.sv
module fwd_id_bypass #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output logic          byp
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    always_comb begin
        byp = wb_wr && (src != ZERO_REG) && (src == wb_dst);
    end
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic [AW-1:0]           ex_dst,
    input  logic                    ex_wr,
    input  logic                    ex_load,
    output logic                    stall
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] dep;

    for (genvar g = 0; g < NSRC; g++) begin : g_dep
        assign dep[g] = (id_src[g] == ex_dst);
    end

    always_comb begin
        stall = ex_wr && ex_load && (ex_dst != ZERO_REG) && (|dep);
    end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_load,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_wr,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b,
    output logic          id_byp_a,
    output logic          id_byp_b,
    output logic          stall
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][AW-1:0] ex_src;
    logic [NSRC-1:0][AW-1:0] id_src;
    fwd_sel_e [NSRC-1:0]     ex_sel;
    logic [NSRC-1:0]         id_byp;

    assign ex_src = {ex_src_b, ex_src_a};
    assign id_src = {id_src_b, id_src_a};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        fwd_ex_select #(.AW(AW)) u_ex_sel (
            .src      (ex_src[g]),
            .mem_dst  (mem_dst),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .wb_dst   (wb_dst),
            .wb_wr    (wb_wr),
            .sel      (ex_sel[g])
        );
        fwd_id_bypass #(.AW(AW)) u_id_byp (
            .src    (id_src[g]),
            .wb_dst (wb_dst),
            .wb_wr  (wb_wr),
            .byp    (id_byp[g])
        );
    end

    fwd_load_use #(.AW(AW), .NSRC(NSRC)) u_load_use (
        .id_src  (id_src),
        .ex_dst  (ex_dst),
        .ex_wr   (ex_wr),
        .ex_load (ex_load),
        .stall   (stall)
    );

    assign ex_sel_a = ex_sel[0];
    assign ex_sel_b = ex_sel[1];
    assign id_byp_a = id_byp[0];
    assign id_byp_b = id_byp[1];
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] ex_src_a,
    input logic          ex_wr,
    input logic          ex_load,
    input logic          mem_wr,
    input logic          mem_load,
    input logic          wb_wr,
    input logic [1:0]    ex_sel_a,
    input logic [1:0]    ex_sel_b,
    input logic          id_byp_a,
    input logic          stall
);
    always_comb begin
        // R1
        sel_code_chk: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11);
        // R5
        zero_src_chk: assert (!(ex_src_a == '0 && ex_sel_a != 2'b00));
        // R5
        zero_id_chk: assert (!(id_src_a == '0 && id_byp_a));
        // R6
        mem_we_chk: assert (!(ex_sel_a == 2'b01 && !mem_wr));
        // R7
        mem_load_chk: assert (!(ex_sel_a == 2'b01 && mem_load));
        // R6
        wb_we_chk: assert (!(ex_sel_a == 2'b10 && !wb_wr));
        // R10
        stall_load_chk: assert (!(stall && !(ex_load && ex_wr)));
    end
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.AW(AW)) u_fwd_hazard_chk (
    .id_src_a (id_src_a),
    .ex_src_a (ex_src_a),
    .ex_wr    (ex_wr),
    .ex_load  (ex_load),
    .mem_wr   (mem_wr),
    .mem_load (mem_load),
    .wb_wr    (wb_wr),
    .ex_sel_a (ex_sel_a),
    .ex_sel_b (ex_sel_b),
    .id_byp_a (id_byp_a),
    .stall    (stall)
);

// File: tb/fwd_hazard_unit_bench.sv
module fwd_hazard_unit_bench;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
    logic ex_wr, ex_load, mem_wr, mem_load, wb_wr;
    logic [1:0] ex_sel_a, ex_sel_b;
    logic id_byp_a, id_byp_b, stall;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    fwd_hazard_unit #(.AW(AW)) u_fwd_hazard_unit (
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wr(wb_wr),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .id_byp_a(id_byp_a), .id_byp_b(id_byp_b), .stall(stall)
    );

    // Reference model: expected select for one EX operand
    function automatic int exp_sel(int s);
        bit m, w;
        m = (s != 0) && mem_wr && !mem_load && (int'(mem_dst) == s);
        w = (s != 0) && wb_wr && (int'(wb_dst) == s);
        if (m) return 1;
        if (w) return 2;
        return 0;
    endfunction

    function automatic string sel_tag(int s);
        bit mm, wm;
        mm = (int'(mem_dst) == s);
        wm = (int'(wb_dst) == s);
        if (s == 0) return "R5";
        if (mm && mem_wr && mem_load) return "R7";
        if (mm && mem_wr && wm && wb_wr) return "R4";
        if (mm && mem_wr) return "R2";
        if (wm && wb_wr) return "R3";
        if (mm || wm) return "R6";
        return "R1";
    endfunction

    function automatic int exp_byp(int s);
        return ((s != 0) && wb_wr && (int'(wb_dst) == s)) ? 1 : 0;
    endfunction

    function automatic int exp_stall();
        bit dep;
        dep = (id_src_a == ex_dst) || (id_src_b == ex_dst);
        return (ex_wr && ex_load && ex_dst != 0 && dep) ? 1 : 0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string st;
        check(sel_tag(int'(ex_src_a)), "ex_sel_a", int'(ex_sel_a), exp_sel(int'(ex_src_a)));
        check(sel_tag(int'(ex_src_b)), "ex_sel_b", int'(ex_sel_b), exp_sel(int'(ex_src_b)));
        check(id_src_a == 0 ? "R5" : "R8", "id_byp_a", int'(id_byp_a), exp_byp(int'(id_src_a)));
        check(id_src_b == 0 ? "R5" : "R8", "id_byp_b", int'(id_byp_b), exp_byp(int'(id_src_b)));
        st = (!ex_load) ? "R10" : (ex_dst == 0) ? "R5" : (!ex_wr) ? "R6" : "R9";
        check(st, "stall", int'(stall), exp_stall());
    endtask

    task automatic drive(int ia, int ib, int ea, int eb, int ed, bit ew, bit el,
                         int md, bit mw, bit ml, int wd, bit ww);
        @(negedge clk);
        id_src_a = AW'(ia); id_src_b = AW'(ib);
        ex_src_a = AW'(ea); ex_src_b = AW'(eb);
        ex_dst = AW'(ed); ex_wr = ew; ex_load = el;
        mem_dst = AW'(md); mem_wr = mw; mem_load = ml;
        wb_dst = AW'(wd); wb_wr = ww;
        #2;
        compare_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        drive(0,0,0,0,0,0,0,0,0,0,0,0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset/idle state, all zero outputs
        drive(0,0,0,0,0,0,0,0,0,0,0,0);
        check("R1", "idle stall", int'(stall), 0);
        // R2: MEM forward on A
        drive(1,2,3,4,9,1,0,3,1,0,7,1);
        check("R2", "sel_a mem", int'(ex_sel_a), 1);
        // R3: WB forward on B
        drive(1,2,3,4,9,1,0,8,1,0,4,1);
        check("R3", "sel_b wb", int'(ex_sel_b), 2);
        // R4: both match, MEM wins
        drive(1,2,6,6,9,1,0,6,1,0,6,1);
        check("R4", "sel_a prio", int'(ex_sel_a), 1);
        // R5: zero source never forwarded or stalled
        drive(0,0,0,0,0,1,1,0,1,0,0,1);
        check("R5", "sel_a zero", int'(ex_sel_a), 0);
        check("R5", "stall zero", int'(stall), 0);
        // R6: write enable low
        drive(5,5,5,5,5,0,1,5,0,0,5,0);
        check("R6", "sel_a we low", int'(ex_sel_a), 0);
        check("R6", "byp we low", int'(id_byp_a), 0);
        // R7: load in MEM, WB also matches -> WB
        drive(1,2,7,3,9,1,0,7,1,1,7,1);
        check("R7", "sel_a load mem", int'(ex_sel_a), 2);
        // R8: ID bypass
        drive(11,12,1,1,9,1,0,0,0,0,12,1);
        check("R8", "byp_b", int'(id_byp_b), 1);
        // R10: ALU producer with matching dest
        drive(4,4,1,1,4,1,0,0,0,0,0,0);
        check("R10", "no stall alu", int'(stall), 0);
        // R9 / R11: load-use sequence
        drive(5,6,1,2,5,1,1,0,0,0,0,0);
        check("R11", "stall c1", int'(stall), 1);
        drive(5,6,1,2,0,0,0,5,1,1,0,0);
        check("R11", "stall c2", int'(stall), 0);
        drive(8,9,5,6,0,0,0,0,0,0,5,1);
        check("R11", "sel_a c3", int'(ex_sel_a), 2);
        check("R11", "stall c3", int'(stall), 0);
        // Random patterns over a narrow register range
        for (int i = 0; i < 600; i++) begin
            drive($urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
                  $urandom_range(0,3), $urandom_range(0,3), 1'($urandom),
                  1'($urandom), $urandom_range(0,3), 1'($urandom), 1'($urandom),
                  $urandom_range(0,3), 1'($urandom));
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule